// File: doc/BRIEF.md
# Burst Cycle Ready Termination Tracker

This block follows a single bus cycle from the clock in which the address strobe is raised until the cycle completes. When the strobe is accepted, the block records whether the cycle is a single transfer or a multi-beat line fill. It then watches two ready inputs. The non-burst ready input always ends the cycle. Each burst ready input moves the line fill forward by one data beat. The block counts the completed beats and reports each finished transfer on a one-clock strobe. It pulses a done output when the cycle ends, and raises an abort flag in the same clock when the non-burst ready cuts a line fill short.

An active-low last output tells the bus side that the next ready will close the cycle. This lets a requester know ahead of time that the cycle is about to end. Ready inputs have no effect while the block is idle, and none in the first clock of a cycle, which is the strobe clock itself. A clock with neither ready active adds a wait state and changes nothing. All pins are plain control and status signals: the block carries no data stream of its own, so it has no valid/ready handshake and no back-pressure rules.

Top module: `burst_ready_tracker`

## Requirements
- R1: While reset is held and right after it, busy_o, xfer_o, done_o and abort_o are 0, xfer_cnt_o is 0 and last_n_o is 1.
- R2: A strobe_i high while idle starts a cycle: busy_o is 1 and xfer_cnt_o is 0 from the next clock. Ready inputs in the strobe clock cause no transfer and no done.
- R3: Ready inputs while idle with no strobe have no effect: xfer_o and done_o stay 0 and busy_o stays 0.
- R4: While busy, a sampled ready strobes xfer_o high in that clock, and xfer_cnt_o is one higher from the next clock.
- R5: While busy, a clock with neither ready active is a wait state: busy_o stays 1 and xfer_cnt_o holds.
- R6: A line fill (fill_i = 1 at the strobe) of BEATS transfers ends on the BEATS-th burst ready. done_o pulses in that clock and busy_o is 0 from the next clock.
- R7: A single cycle (fill_i = 0 at the strobe) ends on its first ready of either kind, with done_o high and abort_o low.
- R8: When rdy_i and brdy_i are both active in a busy clock, the non-burst ready wins. The cycle ends in that clock with one transfer counted, and a line fill that has not reached its final beat raises abort_o.
- R9: last_n_o is 0 throughout a single cycle, including its strobe clock. In a line fill it is 0 only while xfer_cnt_o equals BEATS-1. It is 1 otherwise.
- R10: A strobe_i while busy is ignored: the cycle in progress keeps its count and its kind.
- R11: abort_o is 1 only when rdy_i ends a line fill before its final beat. A rdy_i on the final beat completes the fill normally, with abort_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Address strobe; starts a cycle when idle |
| fill_i | input | 1 | Sampled with the strobe; 1 selects a BEATS-transfer line fill |
| rdy_i | input | 1 | Non-burst ready; ends the cycle |
| brdy_i | input | 1 | Burst ready; completes one beat |
| busy_o | output | 1 | A cycle is past its strobe clock and sampling readies |
| xfer_o | output | 1 | A transfer completes in this clock |
| xfer_cnt_o | output | $clog2(BEATS+1) | Transfers completed in the current or most recent cycle |
| last_n_o | output | 1 | Active low: the next ready ends the cycle |
| done_o | output | 1 | One-clock pulse when the cycle ends |
| abort_o | output | 1 | One-clock pulse when a line fill is cut short |

## Verification
The bench targets readies that arrive in the strobe clock or while idle. A design that failed to mask them would count a phantom beat or fire done before any data moved. It also drives rdy_i and brdy_i together at every beat position, where a wrong priority would let the fill run on, or would flag an abort on the final beat. Further targets are a strobe arriving mid-cycle, which a faulty design would take as a restart that clears the count, and long runs of wait states, in which a loose counter would drift. The last indicator is compared in every clock, because an off-by-one beat comparison shows up there first.

// File: rtl/burst_ready_tracker_pkg.sv
package burst_ready_tracker_pkg;
  typedef enum logic {
    CYC_IDLE   = 1'b0,
    CYC_ACTIVE = 1'b1
  } cyc_state_e;
endpackage

// File: rtl/brt_ready_qual.sv
module brt_ready_qual (
  input  logic active_i,
  input  logic fill_i,
  input  logic at_last_i,
  input  logic rdy_i,
  input  logic brdy_i,
  output logic xfer_o,
  output logic done_o,
  output logic abort_o
);
  logic burst_ends;

  // a burst ready only closes the cycle on the final beat or on a single cycle
  assign burst_ends = brdy_i & (~fill_i | at_last_i);

  always_comb begin
    xfer_o  = active_i & (rdy_i | brdy_i);
    // non-burst ready wins over burst ready and ends the cycle at once
    done_o  = active_i & (rdy_i | burst_ends);
    abort_o = active_i & rdy_i & fill_i & ~at_last_i;
  end
endmodule

// File: rtl/brt_beat_ctr.sv
module brt_beat_ctr #(
  parameter int BEATS = 4,
  localparam int CW = $clog2(BEATS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          at_last_o
);
  localparam logic [CW-1:0] LAST_IDX = CW'(BEATS - 1);
  localparam logic [CW-1:0] MAX_CNT  = CW'(BEATS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q < MAX_CNT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  generate
    if (BEATS == 1) begin : g_single_beat
      assign at_last_o = 1'b1;
    end else begin : g_multi_beat
      assign at_last_o = (cnt_q == LAST_IDX);
    end
  endgenerate

  assign cnt_o = cnt_q;
endmodule

// File: rtl/burst_ready_tracker.sv
module burst_ready_tracker
  import burst_ready_tracker_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int CW = $clog2(BEATS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_i,
  input  logic          fill_i,
  input  logic          rdy_i,
  input  logic          brdy_i,
  output logic          busy_o,
  output logic          xfer_o,
  output logic [CW-1:0] xfer_cnt_o,
  output logic          last_n_o,
  output logic          done_o,
  output logic          abort_o
);
  cyc_state_e state_q;
  logic       fill_q;
  logic       active;
  logic       accept;
  logic       at_last;
  logic       xfer;
  logic       done;
  logic       abort;
  logic       last_now;

  assign active = (state_q == CYC_ACTIVE);
  // strobe is honoured only when idle; its clock is the cycle's first clock
  assign accept = (state_q == CYC_IDLE) & strobe_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CYC_IDLE;
      fill_q  <= 1'b0;
    end else begin
      unique case (state_q)
        CYC_IDLE: begin
          if (strobe_i) begin
            state_q <= CYC_ACTIVE;
            fill_q  <= fill_i;
          end
        end
        CYC_ACTIVE: begin
          if (done) state_q <= CYC_IDLE;
        end
        default: state_q <= CYC_IDLE;
      endcase
    end
  end

  brt_beat_ctr #(.BEATS(BEATS)) ctr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (accept),
    .inc_i     (xfer),
    .cnt_o     (xfer_cnt_o),
    .at_last_o (at_last)
  );

  brt_ready_qual qual_i (
    .active_i  (active),
    .fill_i    (fill_q),
    .at_last_i (at_last),
    .rdy_i     (rdy_i),
    .brdy_i    (brdy_i),
    .xfer_o    (xfer),
    .done_o    (done),
    .abort_o   (abort)
  );

  // last warning: single cycle from its strobe clock on, fill on its final beat
  always_comb begin
    last_now = (accept & (~fill_i | (BEATS == 1))) | (active & (~fill_q | at_last));
    last_n_o = ~last_now;
  end

  assign busy_o  = active;
  assign xfer_o  = xfer;
  assign done_o  = done;
  assign abort_o = abort;

  AST_IDLE_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!xfer_o && !done_o)); // R3
  AST_STROBE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && strobe_i) |=> (busy_o && xfer_cnt_o == '0)); // R2
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rdy_i && !brdy_i) |=> (busy_o && $stable(xfer_cnt_o))); // R5
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R6
  AST_XFER_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_o && xfer_cnt_o < CW'(BEATS)) |=> (xfer_cnt_o == $past(xfer_cnt_o) + 1'b1)); // R4
  AST_ABORT_ON_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (done_o && rdy_i && xfer_cnt_o < CW'(BEATS - 1))); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_cnt_o <= CW'(BEATS)); // R6
endmodule

// File: tb/burst_ready_tracker_tb_top.sv
`timescale 1ns/1ps
module burst_ready_tracker_tb_top;
  localparam int BEATS = 4;
  localparam int CW = $clog2(BEATS + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, strobe_i, fill_i, rdy_i, brdy_i;
  logic          busy_o, xfer_o, last_n_o, done_o, abort_o;
  logic [CW-1:0] xfer_cnt_o;

  burst_ready_tracker #(.BEATS(BEATS)) dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .fill_i(fill_i),
    .rdy_i(rdy_i), .brdy_i(brdy_i), .busy_o(busy_o), .xfer_o(xfer_o),
    .xfer_cnt_o(xfer_cnt_o), .last_n_o(last_n_o), .done_o(done_o),
    .abort_o(abort_o)
  );

  int errs = 0;
  int checks = 0;
  bit finished = 0;
  bit m_act = 0;
  bit m_fill = 0;
  int m_cnt = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_last_n(bit act, bit fl, int cnt, bit s, bit f);
    bool_last: begin end
    return !((!act && s && !f) || (act && (!fl || cnt == BEATS - 1)));
  endfunction

  task automatic step(bit s, bit f, bit r, bit b, string tag);
    bit at_last, e_x, e_d, e_a;
    @(negedge clk);
    chk("R4", "xfer_cnt_o", int'(xfer_cnt_o), m_cnt);
    chk(tag, "busy_o", int'(busy_o), int'(m_act));
    strobe_i = s; fill_i = f; rdy_i = r; brdy_i = b;
    #1;
    at_last = (m_cnt == BEATS - 1);
    e_x = m_act && (r || b);
    e_d = m_act && (r || (b && (!m_fill || at_last)));
    e_a = m_act && r && m_fill && !at_last;
    chk(tag, "xfer_o", int'(xfer_o), int'(e_x));
    chk(tag, "done_o", int'(done_o), int'(e_d));
    chk("R11", "abort_o", int'(abort_o), int'(e_a));
    chk("R9", "last_n_o", int'(last_n_o), int'(exp_last_n(m_act, m_fill, m_cnt, s, f)));
    if (!m_act && s) begin
      m_act = 1; m_fill = f; m_cnt = 0;
    end else if (m_act) begin
      if (e_x) m_cnt++;
      if (e_d) m_act = 0;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; strobe_i = 0; fill_i = 0; rdy_i = 1; brdy_i = 1;
    repeat (3) @(negedge clk);
    // R1 reset state, readies held active to show they are ignored
    chk("R1", "busy_o", int'(busy_o), 0);
    chk("R1", "xfer_cnt_o", int'(xfer_cnt_o), 0);
    chk("R1", "done_o", int'(done_o), 0);
    chk("R1", "abort_o", int'(abort_o), 0);
    chk("R1", "xfer_o", int'(xfer_o), 0);
    chk("R1", "last_n_o", int'(last_n_o), 1);
    rst_n = 1'b1; rdy_i = 0; brdy_i = 0;

    step(0, 0, 1, 1, "R3");
    step(0, 1, 1, 0, "R3");
    // R2 fill strobe with both readies in the first clock
    step(1, 1, 1, 1, "R2");
    step(0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, "R4");
    step(1, 0, 0, 0, "R10");
    step(0, 0, 0, 1, "R4");
    step(0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, "R6");
    step(0, 0, 0, 0, "R6");
    // R7 single cycles
    step(1, 0, 0, 0, "R7");
    step(0, 0, 1, 0, "R7");
    step(1, 0, 0, 0, "R7");
    step(0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, "R7");
    // R8 both readies mid-fill abort
    step(1, 1, 0, 0, "R8");
    step(0, 0, 0, 1, "R8");
    step(0, 0, 1, 1, "R8");
    step(0, 0, 0, 0, "R8");
    // R11 rdy on the final beat completes normally
    step(1, 1, 0, 0, "R11");
    step(0, 0, 0, 1, "R11");
    step(0, 0, 0, 1, "R11");
    step(0, 0, 0, 1, "R11");
    step(0, 0, 1, 0, "R11");
    step(0, 0, 0, 0, "R11");

    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      bit s, f, r, b;
      s = ($urandom % 3) == 0;
      f = ($urandom % 4) != 0;
      r = ($urandom % 9) == 0;
      b = ($urandom % 3) == 0;
      step(s, f, r, b, "R4");
    end
    step(0, 0, 0, 0, "R5");

    finished = 1;
    summary();
    $finish;
  end
endmodule